// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

The router gathers up to 64 device interrupt request lines into one shared pending vector and fans that vector out to four CPUs. Each CPU owns a 64-bit enable mask. The bitwise AND of that mask and the pending vector is the CPU's routed vector. A CPU's interrupt pin is high while any bit of its routed vector is set. Device lines arrive as single-cycle set and clear pulses, each carrying a 6-bit line number. A set and a clear can arrive in the same cycle.

Software reaches the router through a plain 64-bit register bus. On each cycle with `bus_req` high, the block samples write enable, access size, byte address and write data. `bus_rdata` and `bus_err` are registered and are valid in the cycle after the request. Both are zero in any cycle that follows a cycle with no request. The register index is the byte address shifted right by six, so registers sit 64 bytes apart:

| Index | Byte address | Register | Access |
|---|---|---|---|
| 0 to 3 | 0x000, 0x040, 0x080, 0x0C0 | mask of CPU 0 to 3 | read and write |
| 4 to 7 | 0x100, 0x140, 0x180, 0x1C0 | routed vector of CPU 0 to 3 | read only |
| 8 | 0x200 | pending vector | read only |

The bus is a control path, not a data stream. It has no valid/ready pairing and never stalls. Every request completes in one cycle.

Top module: `dev_irq_router`

## Requirements
- R1: Reset (`rst_n` low) clears all masks and the pending vector. After reset every `cpu_irq` bit, `bus_rdata` and `bus_err` are zero.
- R2: A pulse on `dev_set_en` with index n sets bit n of the pending vector at the next clock edge. The pending vector is readable at byte address 0x200.
- R3: A pulse on `dev_clr_en` with index n clears pending bit n. If bit n is already clear, the pulse is spurious and leaves the pending vector and every `cpu_irq` bit unchanged.
- R4: A set and a clear in the same cycle both take effect when they name different lines. When they name the same line, the set wins and the bit ends up set.
- R5: The routed vector of CPU c always equals mask c AND the pending vector. It is readable at byte address 0x100 + 0x40*c.
- R6: `cpu_irq[c]` is high exactly when the routed vector of CPU c is nonzero. It follows a mask write or a line event at the same clock edge that updates the stored state.
- R7: A full-width write to byte address 0x40*c replaces mask c. A read of that address returns the stored mask.
- R8: The access size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. Any request with a size code other than 3 raises `bus_err`, returns zero read data and changes no state.
- R9: A write to a routed-vector index (4 to 7) or to the pending index (8) raises `bus_err` and changes no state.
- R10: A request to any index above 8 raises `bus_err` and returns zero read data.
- R11: The low six address bits are ignored. Byte address 0x07, for example, reaches mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_set_en | input | 1 | Set pulse for a device line |
| dev_set_idx | input | 6 | Line number for the set pulse |
| dev_clr_en | input | 1 | Clear pulse for a device line |
| dev_clr_idx | input | 6 | Line number for the clear pulse |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_size | input | 2 | Access size code (3 means 8 bytes) |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid the cycle after the request |
| bus_err | output | 1 | Error flag, valid the cycle after the request |
| cpu_irq | output | 4 | Level interrupt, one bit per CPU |

## Verification
The masks are chosen so that CPUs differ: one CPU enables a single low line, one enables two lines, one enables every line and one enables none. A single line event therefore produces a distinct pattern across the four interrupt pins. The bench clears one of two lines routed to the same CPU, which separates "drop the bit" from "drop the whole interrupt". It also issues a spurious clear, so that a clear which toggles a bit instead of forcing it to zero is caught. A set and a clear of the same line in one cycle checks the priority, and the same pair on different lines checks that both events apply. Mask rewrites while a line is pending, plus narrow, read-only, unmapped and low-offset accesses, exercise the decode and error paths.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // Shift from byte address to register index (64-byte stride)
  localparam int REG_SHIFT = 6;

  typedef enum logic [1:0] {
    ACC_B1 = 2'd0,
    ACC_B2 = 2'd1,
    ACC_B4 = 2'd2,
    ACC_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/irq_req_vec.sv
module irq_req_vec #(
  parameter int LINES = 64,
  localparam int LIDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LIDX_W-1:0] set_idx,
  input  logic              clr_en,
  input  logic [LIDX_W-1:0] clr_idx,
  output logic [LINES-1:0]  req_vec
);
  logic [LINES-1:0] req_q, req_nxt;

  // Clear first, then set, so a set of the same line wins
  always_comb begin
    req_nxt = req_q;
    if (clr_en) req_nxt[clr_idx] = 1'b0;
    if (set_en) req_nxt[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_nxt;
  end

  assign req_vec = req_q;
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_CPUS = 4,
  parameter int LINES    = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CPUS-1:0]            mask_we,
  input  logic [LINES-1:0]               wdata,
  input  logic [LINES-1:0]               req_vec,
  output logic [NUM_CPUS-1:0][LINES-1:0] mask_q,
  output logic [NUM_CPUS-1:0][LINES-1:0] routed,
  output logic [NUM_CPUS-1:0]            irq
);
  for (genvar gi = 0; gi < NUM_CPUS; gi++) begin : g_cpu
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mask_q[gi] <= '0;
      else if (mask_we[gi]) mask_q[gi] <= wdata;
    end
    assign routed[gi] = mask_q[gi] & req_vec;
    assign irq[gi]    = |routed[gi];
  end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int LINES    = 64,
  parameter int IDX_W    = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req,
  input  logic                           we,
  input  logic [1:0]                     size,
  input  logic [IDX_W-1:0]               idx,
  input  logic [NUM_CPUS-1:0][LINES-1:0] mask_q,
  input  logic [NUM_CPUS-1:0][LINES-1:0] routed,
  input  logic [LINES-1:0]               req_vec,
  output logic [NUM_CPUS-1:0]            mask_we,
  output logic [LINES-1:0]               rdata,
  output logic                           err
);
  localparam int ROUTE_BASE = NUM_CPUS;
  localparam int PEND_IDX   = 2 * NUM_CPUS;

  logic             full, hit_mask, hit_route, hit_pend, bad;
  logic [LINES-1:0] rd_val;
  logic [LINES-1:0] rdata_q;
  logic             err_q;

  always_comb begin
    full      = (size == ACC_B8);
    hit_mask  = 1'b0;
    hit_route = 1'b0;
    hit_pend  = (idx == IDX_W'(PEND_IDX));
    rd_val    = hit_pend ? req_vec : '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (idx == IDX_W'(c)) begin
        hit_mask = 1'b1;
        rd_val   = mask_q[c];
      end
      if (idx == IDX_W'(ROUTE_BASE + c)) begin
        hit_route = 1'b1;
        rd_val    = routed[c];
      end
    end
    bad = !full || !(hit_mask || hit_route || hit_pend) || (we && !hit_mask);
    for (int c = 0; c < NUM_CPUS; c++)
      mask_we[c] = req && we && !bad && (idx == IDX_W'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= req && bad;
      rdata_q <= (req && !we && !bad) ? rd_val : '0;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int LINES    = 64,
  parameter int ADDR_W   = 12,
  localparam int LIDX_W  = $clog2(LINES),
  localparam int IDX_W   = ADDR_W - REG_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dev_set_en,
  input  logic [LIDX_W-1:0]   dev_set_idx,
  input  logic                dev_clr_en,
  input  logic [LIDX_W-1:0]   dev_clr_idx,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [1:0]          bus_size,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [LINES-1:0]    bus_wdata,
  output logic [LINES-1:0]    bus_rdata,
  output logic                bus_err,
  output logic [NUM_CPUS-1:0] cpu_irq
);
  logic [LINES-1:0]               req_vec;
  logic [NUM_CPUS-1:0][LINES-1:0] mask_q;
  logic [NUM_CPUS-1:0][LINES-1:0] routed;
  logic [NUM_CPUS-1:0]            mask_we;
  logic [IDX_W-1:0]               reg_idx;
  logic                           unused_addr_lo;

  assign reg_idx        = bus_addr[ADDR_W-1:REG_SHIFT];
  assign unused_addr_lo = ^bus_addr[REG_SHIFT-1:0];

  irq_req_vec #(.LINES(LINES)) u_req (
    .clk(clk), .rst_n(rst_n),
    .set_en(dev_set_en), .set_idx(dev_set_idx),
    .clr_en(dev_clr_en), .clr_idx(dev_clr_idx),
    .req_vec(req_vec)
  );

  irq_mask_bank #(.NUM_CPUS(NUM_CPUS), .LINES(LINES)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .mask_we(mask_we), .wdata(bus_wdata), .req_vec(req_vec),
    .mask_q(mask_q), .routed(routed), .irq(cpu_irq)
  );

  irq_reg_decode #(.NUM_CPUS(NUM_CPUS), .LINES(LINES), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .req(bus_req), .we(bus_we), .size(bus_size), .idx(reg_idx),
    .mask_q(mask_q), .routed(routed), .req_vec(req_vec),
    .mask_we(mask_we), .rdata(bus_rdata), .err(bus_err)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_CPUS = 4,
  parameter int LINES    = 64,
  parameter int IDX_W    = 6,
  localparam int LIDX_W  = $clog2(LINES)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           dev_set_en,
  input logic [LIDX_W-1:0]              dev_set_idx,
  input logic                           dev_clr_en,
  input logic [LIDX_W-1:0]              dev_clr_idx,
  input logic                           bus_req,
  input logic                           bus_we,
  input logic [1:0]                     bus_size,
  input logic [IDX_W-1:0]               bus_idx,
  input logic                           bus_err,
  input logic [NUM_CPUS-1:0]            cpu_irq,
  input logic [LINES-1:0]               req_vec,
  input logic [NUM_CPUS-1:0][LINES-1:0] mask_q
);
  a_r1_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_err);

  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    dev_set_en |=> req_vec[$past(dev_set_idx)]);

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clr_en && !(dev_set_en && dev_set_idx == dev_clr_idx)
      |=> !req_vec[$past(dev_clr_idx)]);

  a_r3_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dev_clr_en && !dev_set_en && !req_vec[dev_clr_idx] |=> $stable(req_vec));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dev_set_en && dev_clr_en && dev_set_idx == dev_clr_idx
      |=> req_vec[$past(dev_clr_idx)]);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_vec == '0 |-> cpu_irq == '0);

  a_r8_narrow_err: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size != 2'd3 |=> bus_err);

  a_r8_narrow_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_size != 2'd3 |=> $stable(mask_q));

  a_r9_ro_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_idx >= IDX_W'(NUM_CPUS) |=> bus_err);

  a_r9_ro_write_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_idx >= IDX_W'(NUM_CPUS) |=> $stable(mask_q));
endmodule

bind dev_irq_router irq_router_chk #(
  .NUM_CPUS(NUM_CPUS), .LINES(LINES), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .dev_set_en(dev_set_en), .dev_set_idx(dev_set_idx),
  .dev_clr_en(dev_clr_en), .dev_clr_idx(dev_clr_idx),
  .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
  .bus_idx(reg_idx), .bus_err(bus_err), .cpu_irq(cpu_irq),
  .req_vec(req_vec), .mask_q(mask_q)
);

// File: tb/dev_irq_router_tb_top.sv
module dev_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_set_en = 1'b0, dev_clr_en = 1'b0;
  logic [5:0]  dev_set_idx = '0, dev_clr_idx = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd3;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  cpu_irq;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0] m_mask [4];
  logic [63:0] m_req;

  always #4 clk = ~clk;

  dev_irq_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .dev_set_en(dev_set_en), .dev_set_idx(dev_set_idx),
    .dev_clr_en(dev_clr_en), .dev_clr_idx(dev_clr_idx),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .cpu_irq(cpu_irq)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = |(m_mask[c] & m_req);
    return v;
  endfunction

  // One bus access; result captured one cycle after the request
  task automatic bus(input logic we, input logic [1:0] sz, input logic [11:0] a,
                     input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic line(input logic s, input logic [5:0] si, input logic c, input logic [5:0] ci);
    @(negedge clk);
    dev_set_en = s; dev_set_idx = si; dev_clr_en = c; dev_clr_idx = ci;
    @(negedge clk);
    dev_set_en = 1'b0; dev_clr_en = 1'b0;
  endtask

  task automatic read_chk(string tag, logic [11:0] a, logic [63:0] exp);
    logic [63:0] rd; logic er;
    bus(1'b0, 2'd3, a, '0, rd, er);
    check({tag, " rdata"}, rd, exp);
    check({tag, " err"}, {63'd0, er}, 64'd0);
  endtask

  task automatic wr_mask(int c, logic [63:0] v);
    logic [63:0] rd; logic er;
    bus(1'b1, 2'd3, 12'(c * 64), v, rd, er);
    m_mask[c] = v;
    check("R7 mask write err", {63'd0, er}, 64'd0);
  endtask

  task automatic t_reset();
    check("R1 irq after reset", {60'd0, cpu_irq}, 64'd0);
    check("R1 err after reset", {63'd0, bus_err}, 64'd0);
    for (int c = 0; c < 4; c++) read_chk("R1 mask zero", 12'(c * 64), 64'd0);
    read_chk("R1 pending zero", 12'h200, 64'd0);
  endtask

  task automatic t_route();
    wr_mask(0, 64'h1);
    wr_mask(1, 64'h8000_0000_0000_0020);
    wr_mask(2, '1);
    wr_mask(3, 64'h0);
    read_chk("R7 mask1 readback", 12'h040, m_mask[1]);
    check("R6 no pending no irq", {60'd0, cpu_irq}, 64'd0);
    line(1'b1, 6'd5, 1'b0, 6'd0); m_req[5] = 1'b1;
    check("R6 irq after set 5", {60'd0, cpu_irq}, {60'd0, exp_irq()});
    read_chk("R2 pending after set", 12'h200, m_req);
    line(1'b1, 6'd63, 1'b0, 6'd0); m_req[63] = 1'b1;
    for (int c = 0; c < 4; c++)
      read_chk("R5 routed", 12'(256 + c * 64), m_mask[c] & m_req);
  endtask

  task automatic t_clear();
    line(1'b0, 6'd0, 1'b1, 6'd5); m_req[5] = 1'b0;
    check("R3 irq after clear 5", {60'd0, cpu_irq}, {60'd0, exp_irq()});
    read_chk("R3 routed1 after clear", 12'h140, m_mask[1] & m_req);
    line(1'b0, 6'd0, 1'b1, 6'd63); m_req[63] = 1'b0;
    check("R3 irq after clear 63", {60'd0, cpu_irq}, {60'd0, exp_irq()});
    line(1'b1, 6'd0, 1'b0, 6'd0); m_req[0] = 1'b1;
    line(1'b0, 6'd0, 1'b1, 6'd10);
    check("R3 spurious clear irq", {60'd0, cpu_irq}, {60'd0, exp_irq()});
    read_chk("R3 spurious clear pending", 12'h200, m_req);
  endtask

  task automatic t_both();
    line(1'b1, 6'd7, 1'b1, 6'd7); m_req[7] = 1'b1;
    read_chk("R4 same line set wins", 12'h200, m_req);
    line(1'b1, 6'd8, 1'b1, 6'd7); m_req[8] = 1'b1; m_req[7] = 1'b0;
    read_chk("R4 distinct lines both apply", 12'h200, m_req);
  endtask

  task automatic t_mask();
    wr_mask(3, 64'h100);
    check("R6 irq3 up on mask write", {60'd0, cpu_irq}, {60'd0, exp_irq()});
    wr_mask(3, 64'h0);
    check("R6 irq3 down on mask write", {60'd0, cpu_irq}, {60'd0, exp_irq()});
  endtask

  task automatic t_errors();
    logic [63:0] rd; logic er;
    bus(1'b1, 2'd2, 12'h000, 64'hFFFF, rd, er);
    check("R8 narrow write err", {63'd0, er}, 64'd1);
    read_chk("R8 mask0 unchanged", 12'h000, m_mask[0]);
    bus(1'b0, 2'd0, 12'h000, '0, rd, er);
    check("R8 narrow read err", {63'd0, er}, 64'd1);
    check("R8 narrow read data", rd, 64'd0);
    bus(1'b1, 2'd3, 12'h100, 64'h3, rd, er);
    check("R9 routed write err", {63'd0, er}, 64'd1);
    bus(1'b1, 2'd3, 12'h200, 64'h0, rd, er);
    check("R9 pending write err", {63'd0, er}, 64'd1);
    read_chk("R9 pending unchanged", 12'h200, m_req);
    read_chk("R9 routed0 unchanged", 12'h100, m_mask[0] & m_req);
    bus(1'b0, 2'd3, 12'h240, '0, rd, er);
    check("R10 unmapped err", {63'd0, er}, 64'd1);
    check("R10 unmapped data", rd, 64'd0);
    read_chk("R11 low bits ignored", 12'h007, m_mask[0]);
    read_chk("R11 low bits mask2", 12'h0BF, m_mask[2]);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) m_mask[c] = '0;
    m_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_route();
    t_clear();
    t_both();
    t_mask();
    t_errors();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule